// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This unit executes the bit-manipulation operations of a 32-bit integer core. On an issue cycle it receives a full instruction word plus the values of the two source registers. It decodes the word and computes one of these operations:

- shifts that fill the vacated positions with ones, left or right
- rotations, left or right
- AND with the complement of the second operand
- a plain or a masked population count
- a leading-zero or trailing-zero count
- a bit gather (extract) or a bit scatter (deposit) under a full-width control word

The shift and rotate operations come in a register form and in an immediate form. In the immediate form the amount is taken from the instruction word itself.

The new operations sit beside the base shift, logic and set-less-than operations. They reuse those operations' funct3 values and are told apart by funct7. Any word that is not one of these operations is reported as illegal, and its result reads zero. The result, the illegal flag and a valid strobe are registered, so they appear on the cycle after issue.

Top module: `bitmanip_unit`

## Requirements

Encodings used below:
- Opcodes: OP = 0110011, OP-IMM = 0010011.
- funct3 (instr[14:12]): SLL = 001, SRL = 101, AND = 111, SLT = 010.
- funct7 is instr[31:25]. The rs2 field is instr[24:20].

- R1: OP with funct7 0010000 shifts rs1 left (funct3 SLL) or right (funct3 SRL) by rs2[4:0], filling vacated bits with ones. rs2[31:5] has no effect.
- R2: OP with funct7 0110000 rotates rs1 left (funct3 SLL) or right (funct3 SRL) by rs2[4:0].
- R3: OP-IMM with funct3 SLL or SRL and instr[31:25] equal to 0010000 or 0110000 performs the matching operation from R1 or R2. The amount is instr[24:20], and the rs2 value has no effect.
- R4: OP, funct3 AND, funct7 0100000 returns rs1 & ~rs2.
- R5: OP, funct3 AND, funct7 0101000 returns the number of ones in rs1 & ~rs2.
- R6: OP, funct3 SLT, funct7 0100000, rs2 field 00000 returns the number of ones in rs1. A nonzero rs2 field makes the word illegal.
- R7: OP, funct3 SLT, funct7 0001000, rs2 field 00000 returns the count of leading zeros of rs1, which is 32 for a zero operand.
- R8: OP, funct3 SLT, funct7 0101000, rs2 field 00000 returns the count of trailing zeros of rs1, which is 32 for a zero operand.
- R9: OP, funct3 SLT, funct7 0010000 gathers the rs1 bits at positions where rs2 is one. They are packed into the low result bits with the lowest position first, and the remaining bits are zero.
- R10: OP, funct3 SLT, funct7 0110000 scatters the low bits of rs1, in order, onto the positions where rs2 is one. All other bits are zero.
- R11: Any other word, including base ALU operations, other opcodes, and the counts with a nonzero rs2 field, sets illegal with a zero result.
- R12: The result appears with res_valid high exactly on the cycle after an issue cycle. res_valid is low otherwise, and reset clears all outputs.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An operation is presented this cycle |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First source operand |
| rs2_val | input | 32 | Second source operand / control word |
| res_valid | output | 1 | Result registered from the previous issue |
| illegal | output | 1 | Previous issued word was not recognised |
| result | output | 32 | Operation result, zero when illegal |

## Verification

The hardest situation to reach is one where a word differs from a legal encoding in a single field that the datapath otherwise ignores, such as a count operation with a nonzero rs2 field. Stimulus reaches it by mutating one field of each legal encoding: funct7, funct3, opcode or the rs2 field. Another hard case is an operand that hides the bit ordering of gather and scatter. To cover it, random masks are mixed with all-zero and all-one masks. Every shift amount from 0 to 31 is swept in both forms, with random upper rs2 bits to show they are ignored.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    localparam logic [6:0] OPC_OP    = 7'b0110011;
    localparam logic [6:0] OPC_OPIMM = 7'b0010011;

    localparam logic [2:0] F3_SLL = 3'b001;
    localparam logic [2:0] F3_SRL = 3'b101;
    localparam logic [2:0] F3_AND = 3'b111;
    localparam logic [2:0] F3_SLT = 3'b010;

    localparam logic [6:0] F7_ONES = 7'b0010000;
    localparam logic [6:0] F7_ROT  = 7'b0110000;
    localparam logic [6:0] F7_CPL  = 7'b0100000;
    localparam logic [6:0] F7_LEAD = 7'b0001000;
    localparam logic [6:0] F7_MIX  = 7'b0101000;

    typedef enum logic [3:0] {
        K_NONE,
        K_SHL1,
        K_SHR1,
        K_ROTL,
        K_ROTR,
        K_ANDN,
        K_MCNT,
        K_PCNT,
        K_LZC,
        K_TZC,
        K_GATH,
        K_SCAT
    } bmu_kind_e;

    typedef struct packed {
        bmu_kind_e kind;
        logic      bad;
        logic      imm_amt;
    } bmu_dec_t;

    typedef struct packed {
        logic [6:0] f7;
        logic [4:0] rs2f;
        logic [4:0] rs1f;
        logic [2:0] f3;
        logic [4:0] rdf;
        logic [6:0] opc;
    } bmu_word_t;

    function automatic logic kind_is_left(bmu_kind_e k);
        return (k == K_SHL1) || (k == K_ROTL);
    endfunction

    function automatic logic kind_is_rot(bmu_kind_e k);
        return (k == K_ROTL) || (k == K_ROTR);
    endfunction

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
    import bmu_pkg::*;
(
    input  bmu_word_t word,
    output bmu_dec_t  dec
);

    logic zero_rs2f;
    assign zero_rs2f = (word.rs2f == 5'd0);

    always_comb begin
        dec.kind    = K_NONE;
        dec.imm_amt = 1'b0;
        if (word.opc == OPC_OP) begin
            case (word.f3)
                F3_SLL: begin
                    if (word.f7 == F7_ONES)     dec.kind = K_SHL1;
                    else if (word.f7 == F7_ROT) dec.kind = K_ROTL;
                end
                F3_SRL: begin
                    if (word.f7 == F7_ONES)     dec.kind = K_SHR1;
                    else if (word.f7 == F7_ROT) dec.kind = K_ROTR;
                end
                F3_AND: begin
                    if (word.f7 == F7_CPL)      dec.kind = K_ANDN;
                    else if (word.f7 == F7_MIX) dec.kind = K_MCNT;
                end
                F3_SLT: begin
                    if (word.f7 == F7_ONES)                      dec.kind = K_GATH;
                    else if (word.f7 == F7_ROT)                  dec.kind = K_SCAT;
                    else if (word.f7 == F7_CPL  && zero_rs2f)    dec.kind = K_PCNT;
                    else if (word.f7 == F7_LEAD && zero_rs2f)    dec.kind = K_LZC;
                    else if (word.f7 == F7_MIX  && zero_rs2f)    dec.kind = K_TZC;
                end
                default: dec.kind = K_NONE;
            endcase
        end else if (word.opc == OPC_OPIMM) begin
            dec.imm_amt = 1'b1;
            if (word.f3 == F3_SLL) begin
                if (word.f7 == F7_ONES)     dec.kind = K_SHL1;
                else if (word.f7 == F7_ROT) dec.kind = K_ROTL;
            end else if (word.f3 == F3_SRL) begin
                if (word.f7 == F7_ONES)     dec.kind = K_SHR1;
                else if (word.f7 == F7_ROT) dec.kind = K_ROTR;
            end
        end
        dec.bad = (dec.kind == K_NONE);
    end

endmodule

// File: rtl/bmu_shift.sv
module bmu_shift #(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a,
    input  logic [SHW-1:0]  amt,
    input  logic            left,
    input  logic            rotate,
    output logic [XLEN-1:0] y
);

    logic [2*XLEN-1:0] dbl_l;
    logic [2*XLEN-1:0] dbl_r;
    logic [XLEN-1:0]   inv;

    always_comb begin
        inv   = ~a;
        dbl_l = {a, a} << amt;
        dbl_r = {a, a} >> amt;
        if (rotate) begin
            y = left ? dbl_l[2*XLEN-1:XLEN] : dbl_r[XLEN-1:0];
        end else begin
            y = left ? ~(inv << amt) : ~(inv >> amt);
        end
    end

    // R2: a rotation only moves bits, so the number of ones is unchanged
    always_comb begin
        if (rotate) begin
            p_rot_keeps_ones_r2: assert ($countones(y) == $countones(a))
                else $error("rotate changed the population");
        end
    end

endmodule

// File: rtl/bmu_count.sv
module bmu_count #(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] src,
    output logic [SHW:0]    pop,
    output logic [SHW:0]    lead,
    output logic [SHW:0]    trail
);

    localparam int CW = SHW + 1;

    always_comb begin
        pop = '0;
        for (int i = 0; i < XLEN; i++) begin
            pop = pop + CW'(src[i]);
        end
    end

    always_comb begin
        lead = CW'(XLEN);
        for (int i = 0; i < XLEN; i++) begin
            if (src[i]) lead = CW'(XLEN - 1 - i);
        end
    end

    always_comb begin
        trail = CW'(XLEN);
        for (int i = XLEN - 1; i >= 0; i--) begin
            if (src[i]) trail = CW'(i);
        end
    end

    // R7, R8: a leading plus a trailing count never exceed the width unless the operand is zero
    always_comb begin
        p_counts_fit_r7_r8: assert ((src == '0) ? (lead == CW'(XLEN) && trail == CW'(XLEN))
                                                : (32'(lead) + 32'(trail) < 32'(XLEN)))
            else $error("zero counts out of range");
    end

endmodule

// File: rtl/bmu_perm.sv
module bmu_perm #(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] mask,
    output logic [XLEN-1:0] gathered,
    output logic [XLEN-1:0] scattered
);

    localparam int CW = SHW + 1;

    logic [SHW:0] gk;
    logic [SHW:0] sk;

    always_comb begin
        gathered = '0;
        gk       = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (mask[i]) begin
                gathered[gk[SHW-1:0]] = a[i];
                gk = gk + CW'(1);
            end
        end
    end

    always_comb begin
        scattered = '0;
        sk        = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (mask[i]) begin
                scattered[i] = a[sk[SHW-1:0]];
                sk = sk + CW'(1);
            end
        end
    end

    // R9: a gather never yields more ones than the mask selects
    // R10: a scatter never sets a bit outside the mask
    always_comb begin
        p_gather_bounded_r9: assert ($countones(gathered) <= $countones(mask))
            else $error("gather produced too many ones");
        p_scatter_in_mask_r10: assert ((scattered & ~mask) == '0)
            else $error("scatter wrote outside the mask");
    end

endmodule

// File: rtl/bitmanip_unit.sv
module bitmanip_unit
    import bmu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    output logic            res_valid,
    output logic            illegal,
    output logic [XLEN-1:0] result
);

    localparam int SHW = $clog2(XLEN);
    localparam int CW  = SHW + 1;

    bmu_word_t       word;
    bmu_dec_t        dec;
    logic [SHW-1:0]  amt;
    logic [XLEN-1:0] shifted;
    logic [XLEN-1:0] cnt_src;
    logic [SHW:0]    pop;
    logic [SHW:0]    lead;
    logic [SHW:0]    trail;
    logic [XLEN-1:0] gathered;
    logic [XLEN-1:0] scattered;
    logic [XLEN-1:0] value;
    logic            unused_fields;

    assign word          = bmu_word_t'(instr);
    assign unused_fields = ^{word.rs1f, word.rdf};

    bmu_decode u_decode (
        .word (word),
        .dec  (dec)
    );

    assign amt = dec.imm_amt ? instr[20 +: SHW] : rs2_val[SHW-1:0];

    bmu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
        .a      (rs1_val),
        .amt    (amt),
        .left   (kind_is_left(dec.kind)),
        .rotate (kind_is_rot(dec.kind)),
        .y      (shifted)
    );

    assign cnt_src = (dec.kind == K_MCNT) ? (rs1_val & ~rs2_val) : rs1_val;

    bmu_count #(.XLEN(XLEN), .SHW(SHW)) u_count (
        .src   (cnt_src),
        .pop   (pop),
        .lead  (lead),
        .trail (trail)
    );

    bmu_perm #(.XLEN(XLEN), .SHW(SHW)) u_perm (
        .a         (rs1_val),
        .mask      (rs2_val),
        .gathered  (gathered),
        .scattered (scattered)
    );

    always_comb begin
        case (dec.kind)
            K_SHL1, K_SHR1, K_ROTL, K_ROTR: value = shifted;
            K_ANDN:                         value = rs1_val & ~rs2_val;
            K_MCNT, K_PCNT:                 value = {{(XLEN-CW){1'b0}}, pop};
            K_LZC:                          value = {{(XLEN-CW){1'b0}}, lead};
            K_TZC:                          value = {{(XLEN-CW){1'b0}}, trail};
            K_GATH:                         value = gathered;
            K_SCAT:                         value = scattered;
            default:                        value = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            illegal   <= 1'b0;
            result    <= '0;
        end else begin
            res_valid <= issue;
            if (issue) begin
                illegal <= dec.bad;
                result  <= dec.bad ? '0 : value;
            end
        end
    end

    // R12: one result per issue, on the following cycle only
    p_valid_follows_issue_r12: assert property (@(posedge clk) disable iff (rst)
        issue |=> res_valid);
    p_no_spurious_valid_r12: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !res_valid);

    // R11: a flagged word never carries data
    p_illegal_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (res_valid && illegal) |-> (result == '0));

    // R11: words outside both accepted opcodes are always rejected
    p_foreign_opcode_r11: assert property (@(posedge clk) disable iff (rst)
        (issue && instr[6:0] != OPC_OP && instr[6:0] != OPC_OPIMM) |=> illegal);

    // R6: population count with a nonzero rs2 field is rejected
    p_pcnt_field_r6: assert property (@(posedge clk) disable iff (rst)
        (issue && instr[6:0] == OPC_OP && instr[14:12] == F3_SLT &&
         instr[31:25] == F7_CPL && instr[24:20] != 5'd0) |=> illegal);

    // R4: AND-with-complement relates the result to the issued operands
    p_andn_r4: assert property (@(posedge clk) disable iff (rst)
        (issue && instr[6:0] == OPC_OP && instr[14:12] == F3_AND && instr[31:25] == F7_CPL)
        |=> (!illegal && result == ($past(rs1_val) & ~$past(rs2_val))));

endmodule

// File: tb/bitmanip_unit_tb.sv
module bitmanip_unit_tb;

    localparam int CLK_PERIOD = 10;

    localparam logic [6:0] OP    = 7'b0110011;
    localparam logic [6:0] OPI   = 7'b0010011;
    localparam logic [2:0] SLL   = 3'b001;
    localparam logic [2:0] SRL   = 3'b101;
    localparam logic [2:0] ANDF  = 3'b111;
    localparam logic [2:0] SLTF  = 3'b010;
    localparam logic [6:0] C_ONE = 7'b0010000;
    localparam logic [6:0] C_ROT = 7'b0110000;
    localparam logic [6:0] C_CPL = 7'b0100000;
    localparam logic [6:0] C_LZ  = 7'b0001000;
    localparam logic [6:0] C_MIX = 7'b0101000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic        res_valid;
    logic        illegal;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitmanip_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .issue     (issue),
        .instr     (instr),
        .rs1_val   (rs1_val),
        .rs2_val   (rs2_val),
        .res_valid (res_valid),
        .illegal   (illegal),
        .result    (result)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [31:0] enc(logic [6:0] f7, logic [4:0] r2, logic [2:0] f3, logic [6:0] opc);
        return {f7, r2, 5'd7, f3, 5'd9, opc};
    endfunction

    // mode: 0 shift-left-ones, 1 shift-right-ones, 2 rotate left, 3 rotate right
    function automatic logic [31:0] ref_move(int mode, logic [31:0] a, int n);
        logic [31:0] x = a;
        for (int s = 0; s < n; s++) begin
            case (mode)
                0: x = {x[30:0], 1'b1};
                1: x = {1'b1, x[31:1]};
                2: x = {x[30:0], x[31]};
                default: x = {x[0], x[31:1]};
            endcase
        end
        return x;
    endfunction

    function automatic logic [31:0] ref_pop(logic [31:0] a);
        logic [31:0] x = a;
        int n = 0;
        while (x != 0) begin
            x = x & (x - 1);
            n++;
        end
        return 32'(n);
    endfunction

    function automatic logic [31:0] ref_lead(logic [31:0] a);
        logic [31:0] x = a;
        int n = 0;
        while (n < 32 && x[31] == 1'b0) begin
            x = x << 1;
            n++;
        end
        return 32'(n);
    endfunction

    function automatic logic [31:0] ref_trail(logic [31:0] a);
        logic [31:0] x = a;
        int n = 0;
        while (n < 32 && x[0] == 1'b0) begin
            x = x >> 1;
            n++;
        end
        return 32'(n);
    endfunction

    function automatic logic [31:0] ref_gather(logic [31:0] a, logic [31:0] m);
        logic [31:0] r = '0;
        for (int i = 31; i >= 0; i--) begin
            if (m[i]) r = {r[30:0], a[i]};
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_scatter(logic [31:0] a, logic [31:0] m);
        logic [31:0] r = '0;
        logic [31:0] s = a;
        for (int i = 0; i < 32; i++) begin
            if (m[i]) begin
                r[i] = s[0];
                s = s >> 1;
            end
        end
        return r;
    endfunction

    task automatic run(input string tag, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic e_ill, input logic [31:0] e_val);
        @(negedge clk);
        issue   = 1'b1;
        instr   = ins;
        rs1_val = a;
        rs2_val = b;
        @(negedge clk);
        issue = 1'b0;
        checks++;
        if (res_valid !== 1'b1 || illegal !== e_ill || result !== e_val) begin
            fails++;
            $display("FAIL %s: actual valid=%0b ill=%0b res=%h expected valid=1 ill=%0b res=%h (instr=%h a=%h b=%h)",
                     tag, res_valid, illegal, result, e_ill, e_val, ins, a, b);
        end
    endtask

    task automatic idle_check();
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0) begin
            fails++;
            $display("FAIL R12: actual res_valid=%0b expected 0 after idle cycle", res_valid);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R12: watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] vals [4];

        // R12: reset dominates an issue request
        issue = 1'b1;
        instr = enc(C_CPL, 5'd0, ANDF, OP);
        rs1_val = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || illegal !== 1'b0 || result !== 32'h0) begin
            fails++;
            $display("FAIL R12: reset state actual v=%0b i=%0b r=%h expected 0/0/0",
                     res_valid, illegal, result);
        end
        issue = 1'b0;
        rst = 1'b0;
        idle_check();

        vals[0] = 32'h0;
        vals[1] = 32'hFFFF_FFFF;
        vals[2] = 32'h8000_0001;
        vals[3] = 32'h6C3A_0F95;

        // R1, R2, R3: every amount, both forms, upper rs2 bits random
        for (int sh = 0; sh < 32; sh++) begin
            for (int v = 0; v < 4; v++) begin
                a = vals[v];
                b = {rnd() & 32'hFFFF_FFE0} | 32'(sh);
                run("R1 shl-ones", enc(C_ONE, 5'd2, SLL, OP), a, b, 1'b0, ref_move(0, a, sh));
                run("R1 shr-ones", enc(C_ONE, 5'd2, SRL, OP), a, b, 1'b0, ref_move(1, a, sh));
                run("R2 rotl",     enc(C_ROT, 5'd2, SLL, OP), a, b, 1'b0, ref_move(2, a, sh));
                run("R2 rotr",     enc(C_ROT, 5'd2, SRL, OP), a, b, 1'b0, ref_move(3, a, sh));
                run("R3 shl-ones imm", enc(C_ONE, 5'(sh), SLL, OPI), a, rnd(), 1'b0, ref_move(0, a, sh));
                run("R3 shr-ones imm", enc(C_ONE, 5'(sh), SRL, OPI), a, rnd(), 1'b0, ref_move(1, a, sh));
                run("R3 rotl imm",     enc(C_ROT, 5'(sh), SLL, OPI), a, rnd(), 1'b0, ref_move(2, a, sh));
                run("R3 rotr imm",     enc(C_ROT, 5'(sh), SRL, OPI), a, rnd(), 1'b0, ref_move(3, a, sh));
            end
        end
        idle_check();

        // R4..R10 on random and corner operands
        for (int k = 0; k < 300; k++) begin
            a = rnd();
            b = rnd();
            if (k == 0) begin a = 32'h0;         b = 32'h0;         end
            if (k == 1) begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; end
            if (k == 2) begin a = 32'hFFFF_FFFF; b = 32'h0;         end
            if (k == 3) begin a = 32'h8000_0000; b = 32'h0000_0001; end
            if (k == 4) begin a = 32'h0000_0001; b = 32'h8000_0000; end
            if (k > 4 && k < 100) a = a >> (b % 32);
            run("R4 andn",  enc(C_CPL, 5'd2, ANDF, OP), a, b, 1'b0, a & ~b);
            run("R5 mcnt",  enc(C_MIX, 5'd2, ANDF, OP), a, b, 1'b0, ref_pop(a & ~b));
            run("R6 pcnt",  enc(C_CPL, 5'd0, SLTF, OP), a, b, 1'b0, ref_pop(a));
            run("R7 lzc",   enc(C_LZ,  5'd0, SLTF, OP), a, b, 1'b0, ref_lead(a));
            run("R8 tzc",   enc(C_MIX, 5'd0, SLTF, OP), a, b, 1'b0, ref_trail(a));
            run("R9 gather",  enc(C_ONE, 5'd2, SLTF, OP), a, b, 1'b0, ref_gather(a, b));
            run("R10 scatter", enc(C_ROT, 5'd2, SLTF, OP), a, b, 1'b0, ref_scatter(a, b));
        end

        // R7, R8: single-bit operands at each position
        for (int p = 0; p < 32; p++) begin
            a = 32'h1 << p;
            run("R7 lzc onehot", enc(C_LZ,  5'd0, SLTF, OP), a, 32'h0, 1'b0, 32'(31 - p));
            run("R8 tzc onehot", enc(C_MIX, 5'd0, SLTF, OP), a, 32'h0, 1'b0, 32'(p));
        end

        // R9, R10: contiguous masks at each offset make ordering visible
        for (int p = 0; p < 32; p++) begin
            a = 32'hA5C3_1E69;
            b = 32'hFFFF_FFFF << p;
            run("R9 gather high", enc(C_ONE, 5'd2, SLTF, OP), a, b, 1'b0, a >> p);
            run("R10 scatter high", enc(C_ROT, 5'd2, SLTF, OP), a, b, 1'b0, a << p);
        end

        // R11: near-miss encodings
        for (int k = 0; k < 4; k++) begin
            a = rnd();
            b = rnd();
            run("R11 base sll",    enc(7'b0000000, 5'd2, SLL, OP),  a, b, 1'b1, 32'h0);
            run("R11 base sra",    enc(C_CPL,      5'd2, SRL, OP),  a, b, 1'b1, 32'h0);
            run("R11 base slt",    enc(7'b0000000, 5'd2, SLTF, OP), a, b, 1'b1, 32'h0);
            run("R11 base and",    enc(7'b0000000, 5'd2, ANDF, OP), a, b, 1'b1, 32'h0);
            run("R11 f7 spare",    enc(7'b0000010, 5'd2, SLL, OP),  a, b, 1'b1, 32'h0);
            run("R11 xor ones",    enc(C_ONE,      5'd2, 3'b100, OP), a, b, 1'b1, 32'h0);
            run("R6 pcnt rs2f",    enc(C_CPL, 5'(k + 1), SLTF, OP), a, b, 1'b1, 32'h0);
            run("R11 lzc rs2f",    enc(C_LZ,  5'd3 << k, SLTF, OP), a, b, 1'b1, 32'h0);
            run("R11 tzc rs2f",    enc(C_MIX, 5'd16 >> k, SLTF, OP), a, b, 1'b1, 32'h0);
            run("R11 imm andn",    enc(C_CPL, 5'd2, ANDF, OPI),  a, b, 1'b1, 32'h0);
            run("R11 imm gather",  enc(C_ONE, 5'd2, SLTF, OPI),  a, b, 1'b1, 32'h0);
            run("R11 imm srai",    enc(C_CPL, 5'd2, SRL, OPI),   a, b, 1'b1, 32'h0);
            run("R11 load opcode", enc(C_ONE, 5'd2, SLL, 7'b0000011), a, b, 1'b1, 32'h0);
            run("R11 op-32",       enc(C_ROT, 5'd2, SLL, 7'b0111011), a, b, 1'b1, 32'h0);
        end

        // R11, R12: illegal flag clears on the next legal word, valid drops when idle
        run("R11 recover", enc(C_CPL, 5'd2, ANDF, OP), 32'hF0F0_F0F0, 32'h0FF0_0FF0, 1'b0, 32'hF000_F000);
        idle_check();
        idle_check();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule